// File: doc/BRIEF.md
# Watchdog and Power-On Reset Sequencer

This block is a digital supervisor that owns the chip's active-low reset line. It takes a supply-good flag from an external comparator, a watchdog kick signal from the software-driven logic, and a strap that turns the watchdog on or off. While the supply is bad, reset is held. When the supply turns good, reset stays held for a power-on delay and is then released.

With the watchdog enabled, the block watches the kick signal. Every falling edge of the kick restarts a monitoring period. If a whole monitoring period passes with no falling edge, the block drives a short reset pulse and then starts monitoring again.

All three intervals come from one runtime step length, `base_cnt + 1` system clocks:
- the reset pulse lasts `PULSE_STEPS` steps;
- the monitoring period is 50 times the pulse;
- the power-on delay equals the monitoring period.

One registered low-battery flag passes through unchanged.

Top module: `wdt_por_supervisor`

## Requirements
- R1: `rst_n_o` is 0 from the first clock after a clock edge that samples `supply_ok` low. A loss of `supply_ok` cancels any power-on delay, monitoring period or reset pulse in progress.
- R2: When `supply_ok` is first sampled high after being low, `rst_n_o` stays 0 and rises exactly `50*PULSE_STEPS*(base_cnt+1)` clock cycles after that edge.
- R3: `wd_kick` passes through a two-flop synchroniser. A falling edge is detected by comparing the second synchroniser stage with a third registered copy. While `rst_n_o` is 1 and `wd_en` is 1, each detected falling edge restarts the monitoring period from zero.
- R4: If no falling edge is detected for a full monitoring period of `50*PULSE_STEPS*(base_cnt+1)` clocks, `rst_n_o` goes low for exactly `PULSE_STEPS*(base_cnt+1)` clocks. Monitoring then restarts from zero, so with no kicks the pulses repeat once per period.
- R5: While `wd_en` is 0, no watchdog pulse occurs and the monitoring period is held at zero.
- R6: Kick edges detected while reset is asserted (supply hold, power-on delay or watchdog pulse) have no effect on any timing.
- R7: When a falling kick edge is detected in the same cycle in which the monitoring period would expire, the edge wins: no pulse occurs and monitoring restarts.
- R8: While the synchronous reset `rst` is 1, `rst_n_o` and `low_batt_o` are 0.
- R9: `low_batt_o` equals `low_batt_in` delayed by one clock.
- R10: `base_cnt` sets the step length for all three intervals, keeping the fixed 1:50 ratio. The bench checks this with `base_cnt` set to 0, 1 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply-good flag from the external comparator, synchronous to `clk` |
| wd_en | input | 1 | Watchdog enable strap, 1 = monitoring on |
| wd_kick | input | 1 | Asynchronous watchdog kick; falling edges restart monitoring |
| base_cnt | input | BASE_W | Step length minus one, in clocks |
| low_batt_in | input | 1 | Low-battery flag to pass through |
| rst_n_o | output | 1 | Registered active-low reset output |
| low_batt_o | output | 1 | Registered copy of `low_batt_in` |

## Verification
The critical collision is a detected falling kick edge landing in the same cycle as the expiry of the monitoring period. The bench provokes it by launching the kick from the reference model's own count, so that the edge reaches detection exactly at expiry. It also launches the kick one cycle later, where the pulse must win. The first case must show no low cycle for most of a new period, and the second must show the pulse within a few cycles. A second collision, supply loss during a watchdog pulse, is judged by an immediate reset hold followed by a complete fresh power-on delay.

// File: rtl/wdp_pkg.sv
package wdp_pkg;

  // Ratio between the monitoring period and the watchdog reset pulse.
  localparam int unsigned WD_RATIO = 50;

  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,  // supply bad, reset held
    ST_POR  = 2'd1,  // power-on delay running, reset held
    ST_RUN  = 2'd2,  // reset released, watchdog monitoring
    ST_WDR  = 2'd3   // watchdog reset pulse
  } sup_state_t;

endpackage

// File: rtl/wdp_kick_sync.sv
module wdp_kick_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic kick_async,
  output logic kick_fall
);

  // Stages [SYNC_STAGES-1:0] synchronise; the top stage is the history copy.
  logic [SYNC_STAGES:0] shift_q;

  always_ff @(posedge clk) begin
    if (rst) shift_q <= '1;
    else     shift_q <= {shift_q[SYNC_STAGES-1:0], kick_async};
  end

  assign kick_fall = shift_q[SYNC_STAGES] & ~shift_q[SYNC_STAGES-1];

endmodule

// File: rtl/wdp_step_timer.sv
module wdp_step_timer #(
  parameter int unsigned BASE_W      = 16,
  parameter int unsigned LONG_STEPS  = 50,
  parameter int unsigned SHORT_STEPS = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              long_sel,
  input  logic [BASE_W-1:0] base,
  output logic              done
);

  localparam int unsigned STEP_W = $clog2(LONG_STEPS + 1);
  localparam logic [STEP_W-1:0] LONG_LAST  = STEP_W'(LONG_STEPS - 1);
  localparam logic [STEP_W-1:0] SHORT_LAST = STEP_W'(SHORT_STEPS - 1);

  logic [BASE_W-1:0] pre_q;
  logic [STEP_W-1:0] steps_q;
  logic              step_end;
  logic [STEP_W-1:0] last_step;

  assign step_end  = (pre_q == base);
  assign last_step = long_sel ? LONG_LAST : SHORT_LAST;
  assign done      = step_end && (steps_q == last_step);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pre_q   <= '0;
      steps_q <= '0;
    end else if (step_end) begin
      pre_q   <= '0;
      steps_q <= steps_q + STEP_W'(1);
    end else begin
      pre_q   <= pre_q + BASE_W'(1);
    end
  end

endmodule

// File: rtl/wdt_por_supervisor.sv
module wdt_por_supervisor
  import wdp_pkg::*;
#(
  parameter int unsigned BASE_W      = 16,
  parameter int unsigned PULSE_STEPS = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              supply_ok,
  input  logic              wd_en,
  input  logic              wd_kick,
  input  logic [BASE_W-1:0] base_cnt,
  input  logic              low_batt_in,
  output logic              rst_n_o,
  output logic              low_batt_o
);

  localparam int unsigned MON_STEPS = WD_RATIO * PULSE_STEPS;

  sup_state_t state_q, state_d;
  logic       kick_fall;
  logic       t_done;
  logic       t_clear;

  wdp_kick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .kick_async (wd_kick),
    .kick_fall  (kick_fall)
  );

  wdp_step_timer #(
    .BASE_W      (BASE_W),
    .LONG_STEPS  (MON_STEPS),
    .SHORT_STEPS (PULSE_STEPS)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .clear    (t_clear),
    .long_sel (state_q != ST_WDR),
    .base     (base_cnt),
    .done     (t_done)
  );

  // Supply loss has top priority; a kick edge beats expiry in RUN.
  always_comb begin
    state_d = state_q;
    t_clear = 1'b0;
    unique case (state_q)
      ST_HOLD: begin
        state_d = ST_POR;
        t_clear = 1'b1;
      end
      ST_POR: begin
        if (t_done) begin
          state_d = ST_RUN;
          t_clear = 1'b1;
        end
      end
      ST_RUN: begin
        if (!wd_en || kick_fall) begin
          t_clear = 1'b1;
        end else if (t_done) begin
          state_d = ST_WDR;
          t_clear = 1'b1;
        end
      end
      ST_WDR: begin
        if (t_done) begin
          state_d = ST_RUN;
          t_clear = 1'b1;
        end
      end
      default: begin
        state_d = ST_HOLD;
        t_clear = 1'b1;
      end
    endcase
    if (!supply_ok) begin
      state_d = ST_HOLD;
      t_clear = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_HOLD;
      rst_n_o    <= 1'b0;
      low_batt_o <= 1'b0;
    end else begin
      state_q    <= state_d;
      rst_n_o    <= (state_d == ST_RUN);
      low_batt_o <= low_batt_in;
    end
  end

  // R1: supply loss forces reset on the next cycle
  a_r1_supply_low_holds: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> !rst_n_o);

  // R8: synchronous reset keeps the output asserted
  a_r8_reset_asserted: assert property (@(posedge clk)
    rst |=> (!rst_n_o && !low_batt_o));

  // R4: the end of a watchdog pulse releases reset
  a_r4_pulse_releases: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WDR && t_done && supply_ok) |=> rst_n_o);

  // R5: a disabled watchdog never leaves monitoring
  a_r5_disabled_stays_run: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && !wd_en && supply_ok) |=> (state_q == ST_RUN));

  // R6: a kick during the power-on delay does not end it
  a_r6_por_kick_ignored: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_POR && !t_done && kick_fall && supply_ok) |=> (state_q == ST_POR));

  // R7: a kick edge keeps reset released, even at expiry
  a_r7_kick_beats_expiry: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && wd_en && kick_fall && supply_ok) |=> (rst_n_o && state_q == ST_RUN));

endmodule

// File: tb/wdt_por_supervisor_tb.sv
module wdt_por_supervisor_tb;

  localparam int BW    = 16;
  localparam int RATIO = 50;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst  = 1'b1;
  logic          sup  = 1'b0;
  logic          wden = 1'b1;
  logic          kick = 1'b1;
  logic          lbi  = 1'b0;
  logic [BW-1:0] base = '0;
  logic          rstn, lbo;

  wdt_por_supervisor #(.BASE_W(BW), .PULSE_STEPS(1), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .supply_ok(sup), .wd_en(wden), .wd_kick(kick),
    .base_cnt(base), .low_batt_in(lbi), .rst_n_o(rstn), .low_batt_o(lbo)
  );

  int    n_chk = 0, n_fail = 0, lbc = 0, cyc = 0;
  bit    done_f = 1'b0;
  string tag = "R8";

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    lbc++;
    lbi = ((lbc % 7) < 3);
  endtask

  task automatic run(input int cycles, inout int lows);
    repeat (cycles) begin
      step();
      if (!rstn) lows++;
    end
  endtask

  // Behavioural reference: 0 hold, 1 power-on, 2 monitoring, 3 pulse
  int m_st = 0, m_cnt = 0;
  bit k1 = 1, k2 = 1, k3 = 1, e_n = 0, e_lb = 0;

  always @(posedge clk) begin
    int per, pw;
    bit fall;
    per = (int'(base) + 1) * RATIO;
    pw  = int'(base) + 1;
    if (rst) begin
      m_st = 0; m_cnt = 0; k1 = 1; k2 = 1; k3 = 1; e_n = 0; e_lb = 0;
    end else begin
      fall = k3 && !k2;
      k3 = k2; k2 = k1; k1 = kick;
      if (!sup) begin
        m_st = 0; m_cnt = 0;
      end else begin
        case (m_st)
          0: begin m_st = 1; m_cnt = 0; end
          1: if (m_cnt == per - 1) begin m_st = 2; m_cnt = 0; end else m_cnt++;
          2: if (!wden || fall) m_cnt = 0;
             else if (m_cnt == per - 1) begin m_st = 3; m_cnt = 0; end
             else m_cnt++;
          default: if (m_cnt == pw - 1) begin m_st = 2; m_cnt = 0; end else m_cnt++;
        endcase
      end
      e_n  = (m_st == 2);
      e_lb = lbi;
    end
  end

  always @(negedge clk) begin
    if (!done_f) begin
      chk(rst ? "R8" : tag, int'(rstn), int'(e_n));
      chk("R9", int'(lbo), int'(e_lb));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done_f) begin
      done_f = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic measure_release(input string req, input int per);
    int n;
    n = 0;
    sup = 1'b1;
    do begin step(); n++; end while (!rstn && n < 20000);
    chk(req, n, per + 1);
  endtask

  task automatic measure_pulse(input string req, input int pw);
    int n, w;
    n = 0;
    while (rstn && n < 20000) begin step(); n++; end
    w = 0;
    while (!rstn && w < 20000) begin w++; step(); end
    chk(req, w, pw);
  endtask

  initial begin
    int per, lows, g, n;
    // R8: reset state
    repeat (3) step();
    chk("R8", int'(rstn), 0);
    chk("R8", int'(lbo), 0);
    rst = 1'b0;

    // R2: power-on delay with base_cnt = 1
    base = 16'd1; per = 2 * RATIO;
    repeat (4) step();
    tag = "R2";
    measure_release("R2", per);

    // R3: regular kicks keep reset released
    tag = "R3"; lows = 0;
    repeat (8) begin
      kick = 1'b0; run(3, lows);
      kick = 1'b1; run(37, lows);
    end
    chk("R3", lows, 0);

    // R4: kicks stop, pulses repeat once per period
    tag = "R4";
    measure_pulse("R4 width", 2);
    g = 0;
    while (rstn && g < 20000) begin step(); g++; end
    chk("R4 period", g, per);
    n = 0;
    while (!rstn && n < 20000) begin n++; step(); end
    chk("R4 second width", n, 2);

    // R7: kick edge detected in the expiry cycle wins
    tag = "R7";
    while (!(m_st == 2 && m_cnt == per - 3)) step();
    kick = 1'b0; repeat (3) step(); kick = 1'b1;
    lows = 0; run(per - 5, lows);
    chk("R7 coincident kick", lows, 0);
    // One cycle late: the pulse wins and the edge is ignored (R6)
    while (!(m_st == 2 && m_cnt == per - 2)) step();
    lows = 0; kick = 1'b0; run(3, lows); kick = 1'b1;
    chk("R7 late kick", int'(lows > 0), 1);

    // R5: watchdog disabled
    tag = "R5";
    n = 0;
    while (!rstn && n < 20000) begin step(); n++; end
    wden = 1'b0; lows = 0; run(400, lows);
    chk("R5", lows, 0);
    wden = 1'b1;

    // R1: supply loss asserts reset at once
    tag = "R1";
    sup = 1'b0; step();
    chk("R1", int'(rstn), 0);
    repeat (4) step();

    // R6: kick toggling during power-on delay changes nothing
    tag = "R6"; n = 0; sup = 1'b1;
    do begin step(); n++; if (n % 5 == 0) kick = ~kick; end while (!rstn && n < 20000);
    chk("R6", n, per + 1);
    kick = 1'b1;

    // R10: base_cnt = 0 and base_cnt = 3
    tag = "R10";
    sup = 1'b0; repeat (3) step();
    base = 16'd0;
    measure_release("R10 release base0", RATIO);
    measure_pulse("R10 width base0", 1);
    sup = 1'b0; repeat (3) step();
    base = 16'd3; per = 4 * RATIO;
    measure_release("R10 release base3", per);
    measure_pulse("R10 width base3", 4);

    // R1: supply loss in the middle of a watchdog pulse
    tag = "R1";
    n = 0;
    while (rstn && n < 20000) begin step(); n++; end
    sup = 1'b0; step();
    chk("R1 abort pulse", int'(rstn), 0);
    repeat (3) step();
    measure_release("R1 fresh delay", per);

    done_f = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule